// File: doc/BRIEF.md
# Burst-Capable Flash Read Front End

This block is the device-side read path of a NOR-style memory with separate address and data buses. It watches the chip enable, output enable, write enable, address-valid and reset pins and an address bus. It returns 16-bit words from a small array that is split into four banks. All pins are sampled on the rising edge of `clk_i`. The active-low `rst_ni` is the hardware reset pin.

Two read styles are supported. In asynchronous mode, the address presented while address-valid is low is held in a latch, and the word at that address is shown on the data bus. In burst mode, the same latch takes a starting address. Every later clock edge then steps it forward, either without limit or inside an aligned window of 8, 16 or 32 words. A burst is ended or restarted by the chip enable, by reset, or by a new address-valid pulse. A one-bit mode input and a two-bit length code take the place of the unmodelled command-register write. Both are taken only while the chip is deselected.

Top module: `flash_rd_front`

## Requirements
- R1: After `rst_ni` is released, the block is in asynchronous mode with the address latch at 0, and clock edges with `avd_ni` high do not change the address.
- R2: The address latch takes `addr_i` on each clock edge where `ce_ni` and `avd_ni` are both low. In asynchronous mode it holds its value on every edge where `avd_ni` is high.
- R3: `dq_oe_o` is 1 exactly when `ce_ni`=0, `oe_ni`=0 and `we_ni`=1, and `dq_o` is 0 whenever `dq_oe_o` is 0. While `dq_oe_o` is 1, `dq_o` equals the word stored at the latched address.
  - The word stored at address a is the low 16 bits of (a*40503) XOR 16'hC3A5.
  - The bank is given by the top two address bits.
- R4: `burst_mode_i` (1 = burst) and `burst_len_i` are taken only on edges where `ce_ni` is high. Changes to them while `ce_ni` is low have no effect.
- R5: In burst mode, an edge with `ce_ni` and `avd_ni` low loads the start address. Each later edge with `ce_ni` low and `avd_ni` high advances the address by one.
- R6: An edge with `ce_ni` high ends the burst. After `ce_ni` falls again, the address does not advance until a new start address is loaded.
- R7: An edge with `avd_ni` low during a running burst drops that burst. A new burst then starts at the newly presented `addr_i`.
- R8: With `burst_len_i`=0 (continuous), the address increments across bank boundaries and wraps from the top of the address space to 0.
- R9: `burst_len_i` codes 1, 2 and 3 select an aligned wrap window of 8, 16 or 32 words. The address steps within that window, and the bits above the window never change.
- R10: Driving `rst_ni` low during a burst ends it. The block then returns to asynchronous mode with the address at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Burst clock, rising edge active |
| rst_ni | input | 1 | Hardware reset, active low, asynchronous |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low (must be high to read) |
| avd_ni | input | 1 | Address valid, active low |
| addr_i | input | ADDR_W | Word address |
| burst_mode_i | input | 1 | 1 selects burst reads, 0 asynchronous (taken while deselected) |
| burst_len_i | input | 2 | 0 continuous, 1/2/3 wrap 8/16/32 (taken while deselected) |
| dq_o | output | 16 | Read data, 0 while not driven |
| dq_oe_o | output | 1 | Data bus drive enable; low means high impedance |

## Verification
The bench builds the block with the default 8-bit address. With that width, the 64-word banks are small enough that a continuous burst crosses from bank 0 into bank 1, and a start address of 0xFF shows the wrap to 0. The 32-word window at 0xE0 to 0xFF sits at the very top of the address space, so the wrap point and the top address are the same. Each wrap window is started near its upper edge, so one or two clocks show the fold back to the aligned base.

// File: rtl/flash_rd_pkg.sv
package flash_rd_pkg;
  localparam int DATA_W = 16;
  localparam int BANK_W = 2;
  localparam int NBANK  = 1 << BANK_W;

  typedef enum logic [1:0] {
    ST_ASYNC     = 2'd0,
    ST_SYNC_IDLE = 2'd1,
    ST_SYNC_RUN  = 2'd2
  } rd_state_e;

  typedef enum logic [1:0] {
    BL_CONT   = 2'd0,
    BL_WRAP8  = 2'd1,
    BL_WRAP16 = 2'd2,
    BL_WRAP32 = 2'd3
  } blen_e;

  // array content is a fixed hash of the word address
  function automatic logic [DATA_W-1:0] cell_word(input logic [31:0] a);
    logic [31:0] p;
    p = a * 32'd40503;
    return p[DATA_W-1:0] ^ 16'hC3A5;
  endfunction
endpackage

// File: rtl/flash_mode_fsm.sv
module flash_mode_fsm
  import flash_rd_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      ce_ni,
  input  logic      avd_ni,
  input  logic      mode_i,
  input  logic [1:0] blen_i,
  output rd_state_e st_o,
  output blen_e     blen_o,
  output logic      load_o,
  output logic      step_o
);
  rd_state_e st_q, st_d;
  blen_e     blen_q;

  always_comb begin
    st_d = st_q;
    if (ce_ni)
      st_d = mode_i ? ST_SYNC_IDLE : ST_ASYNC;
    else if (st_q == ST_SYNC_IDLE && !avd_ni)
      st_d = ST_SYNC_RUN;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_ASYNC;
      blen_q <= BL_CONT;
    end else begin
      st_q <= st_d;
      if (ce_ni) blen_q <= blen_e'(blen_i);
    end
  end

  assign load_o = !ce_ni && !avd_ni;
  assign step_o = !ce_ni && avd_ni && (st_q == ST_SYNC_RUN);
  assign st_o   = st_q;
  assign blen_o = blen_q;
endmodule

// File: rtl/flash_addr_ctr.sv
module flash_addr_ctr
  import flash_rd_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              step_i,
  input  blen_e             blen_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_q, win, inc, nxt;

  always_comb begin
    unique case (blen_i)
      BL_WRAP8:  win = ADDR_W'(7);
      BL_WRAP16: win = ADDR_W'(15);
      BL_WRAP32: win = ADDR_W'(31);
      default:   win = '1;
    endcase
    inc = addr_q + ADDR_W'(1);
    nxt = (addr_q & ~win) | (inc & win);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_q <= '0;
    else if (load_i) addr_q <= addr_i;
    else if (step_i) addr_q <= nxt;
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/flash_bank.sv
module flash_bank
  import flash_rd_pkg::*;
#(
  parameter int OFFS_W  = 6,
  parameter int BANK_ID = 0
) (
  input  logic              en_i,
  input  logic [OFFS_W-1:0] offs_i,
  output logic [DATA_W-1:0] word_o
);
  logic [31:0] full_a;

  assign full_a = (32'(BANK_ID) << OFFS_W) | 32'(offs_i);
  assign word_o = en_i ? cell_word(full_a) : '0;
endmodule

// File: rtl/flash_rd_front.sv
module flash_rd_front
  import flash_rd_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  input  logic              avd_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              burst_mode_i,
  input  logic [1:0]        burst_len_i,
  output logic [15:0]       dq_o,
  output logic              dq_oe_o
);
  localparam int OFFS_W = ADDR_W - BANK_W;

  rd_state_e         st_q;
  blen_e             blen_q;
  logic              load, step;
  logic [ADDR_W-1:0] addr_q;
  logic [NBANK-1:0]  bank_en;
  logic [DATA_W-1:0] bank_word [NBANK];
  logic [DATA_W-1:0] rd_word;

  flash_mode_fsm u_fsm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ce_ni  (ce_ni),
    .avd_ni (avd_ni),
    .mode_i (burst_mode_i),
    .blen_i (burst_len_i),
    .st_o   (st_q),
    .blen_o (blen_q),
    .load_o (load),
    .step_o (step)
  );

  flash_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .step_i (step),
    .blen_i (blen_q),
    .addr_i (addr_i),
    .addr_o (addr_q)
  );

  assign bank_en = NBANK'(1) << addr_q[ADDR_W-1 -: BANK_W];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    flash_bank #(.OFFS_W(OFFS_W), .BANK_ID(b)) u_bank (
      .en_i   (bank_en[b]),
      .offs_i (addr_q[OFFS_W-1:0]),
      .word_o (bank_word[b])
    );
  end

  always_comb begin
    rd_word = '0;
    for (int b = 0; b < NBANK; b++) rd_word = rd_word | bank_word[b];
  end

  assign dq_oe_o = !ce_ni && !oe_ni && we_ni;
  assign dq_o    = dq_oe_o ? rd_word : '0;
endmodule

// File: rtl/flash_rd_front_chk.sv
module flash_rd_front_chk
  import flash_rd_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ce_ni,
  input logic              avd_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic [15:0]       dq_o,
  input logic              dq_oe_o,
  input logic [1:0]        st_i,
  input logic [1:0]        blen_i,
  input logic [ADDR_W-1:0] addr_q_i
);
  // R2
  async_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_ASYNC && avd_ni) |=> $stable(addr_q_i));
  // R3
  read_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> (dq_o == cell_word(32'(addr_q_i))));
  // R4
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_ni |=> $stable(blen_i));
  // R5
  burst_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_SYNC_RUN && !ce_ni && avd_ni) |=> (addr_q_i != $past(addr_q_i)));
  // R6
  ce_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_ni |=> (st_i != ST_SYNC_RUN));
  // R7
  addr_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_ni && !avd_ni) |=> (addr_q_i == $past(addr_i)));
  // R9
  wrap_upper_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_SYNC_RUN && !ce_ni && avd_ni && blen_i != BL_CONT)
      |=> (addr_q_i[ADDR_W-1:5] == $past(addr_q_i[ADDR_W-1:5])));
endmodule

bind flash_rd_front flash_rd_front_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ce_ni    (ce_ni),
  .avd_ni   (avd_ni),
  .addr_i   (addr_i),
  .dq_o     (dq_o),
  .dq_oe_o  (dq_oe_o),
  .st_i     (st_q),
  .blen_i   (blen_q),
  .addr_q_i (addr_q)
);

// File: tb/flash_rd_front_bench.sv
module flash_rd_front_bench;
  localparam int CLK_P = 10;
  localparam int AW    = 8;

  typedef struct packed {
    logic       ce, oe, we, avd, mode;
    logic [1:0] len;
    logic [7:0] addr;
    logic       eoe;
    logic [7:0] ea;
    logic [7:0] req;
  } vec_t;

  localparam int NV = 37;
  // fields: ce oe we avd mode len addr | exp_drive exp_addr req
  localparam vec_t VEC [NV] = '{
    '{1,1,1,1,0,0,8'h00,0,8'h00,3},  // R3 deselected
    '{0,1,1,0,0,0,8'h25,0,8'h25,3},  // R3 oe high
    '{0,0,1,1,0,0,8'h99,1,8'h25,2},  // R2 held
    '{0,0,1,1,0,0,8'h99,1,8'h25,2},
    '{0,0,0,1,0,0,8'h99,0,8'h25,3},  // R3 we low
    '{0,0,1,0,1,3,8'h44,1,8'h44,4},  // R4 mode ignored
    '{0,0,1,1,1,3,8'h44,1,8'h44,4},
    '{1,1,1,1,1,0,8'h00,0,8'h44,4},  // select burst
    '{0,0,1,0,1,0,8'h3E,1,8'h3E,5},  // R5
    '{0,0,1,1,1,0,8'h00,1,8'h3F,5},
    '{0,0,1,1,1,0,8'h00,1,8'h40,8},  // R8 bank cross
    '{0,0,1,0,1,0,8'h7D,1,8'h7D,7},  // R7 restart
    '{0,0,1,1,1,0,8'h00,1,8'h7E,7},
    '{1,0,1,1,1,1,8'h00,0,8'h7E,6},  // R6 end
    '{0,0,1,1,1,1,8'h00,1,8'h7E,6},
    '{0,0,1,1,1,1,8'h00,1,8'h7E,6},
    '{0,0,1,0,1,1,8'h16,1,8'h16,9},  // R9 wrap 8
    '{0,0,1,1,0,0,8'h00,1,8'h17,4},
    '{0,0,1,1,0,0,8'h00,1,8'h10,9},
    '{0,0,1,1,0,0,8'h00,1,8'h11,9},
    '{1,1,1,1,1,2,8'h00,0,8'h11,9},  // wrap 16
    '{0,0,1,0,1,2,8'h4D,1,8'h4D,9},
    '{0,0,1,1,1,2,8'h00,1,8'h4E,9},
    '{0,0,1,1,1,2,8'h00,1,8'h4F,9},
    '{0,0,1,1,1,2,8'h00,1,8'h40,9},
    '{1,1,1,1,1,3,8'h00,0,8'h40,9},  // wrap 32
    '{0,0,1,0,1,3,8'hFE,1,8'hFE,9},
    '{0,0,1,1,1,3,8'h00,1,8'hFF,9},
    '{0,0,1,1,1,3,8'h00,1,8'hE0,9},
    '{0,0,1,1,1,3,8'h00,1,8'hE1,9},
    '{1,1,1,1,1,0,8'h00,0,8'hE1,8},  // continuous
    '{0,0,1,0,1,0,8'hFF,1,8'hFF,8},
    '{0,0,1,1,1,0,8'h00,1,8'h00,8},  // R8 top wrap
    '{1,1,1,1,0,0,8'h00,0,8'h00,2},  // back to async
    '{0,0,1,0,0,0,8'h11,1,8'h11,2},
    '{0,0,1,1,0,0,8'h00,1,8'h11,2},
    '{0,0,1,1,0,0,8'h00,1,8'h11,2}
  };

  logic          clk = 0, rst_n = 0;
  logic          ce_n = 1, oe_n = 1, we_n = 1, avd_n = 1, mode = 0;
  logic [1:0]    blen = 0;
  logic [AW-1:0] addr = 0;
  logic [15:0]   dq;
  logic          dq_oe;
  int            n_run = 0, n_fail = 0;
  bit            done = 0;

  always #(CLK_P/2) clk = ~clk;

  flash_rd_front #(.ADDR_W(AW)) u_flash_rd_front (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .oe_ni(oe_n), .we_ni(we_n),
    .avd_ni(avd_n), .addr_i(addr), .burst_mode_i(mode), .burst_len_i(blen),
    .dq_o(dq), .dq_oe_o(dq_oe)
  );

  function automatic logic [15:0] exp_word(input int unsigned a);
    logic [31:0] p;
    p = a * 32'd40503;
    return p[15:0] ^ 16'hC3A5;
  endfunction

  task automatic check_bus(input logic eoe, input logic [7:0] ea, input string tag);
    logic [15:0] w;
    w = eoe ? exp_word(32'(ea)) : 16'h0;
    n_run++;
    if (dq_oe !== eoe || dq !== w) begin
      n_fail++;
      $display("FAIL %s: oe=%0b dq=%h, expected oe=%0b dq=%h", tag, dq_oe, dq, eoe, w);
    end
  endtask

  task automatic drive(input logic c, o, w, a, m, input logic [1:0] l, input logic [7:0] ad);
    @(negedge clk);
    ce_n = c; oe_n = o; we_n = w; avd_n = a; mode = m; blen = l; addr = ad;
  endtask

  task automatic cyc_check(input logic eoe, input logic [7:0] ea, input string tag);
    @(posedge clk);
    #1;
    check_bus(eoe, ea, tag);
  endtask

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    // R1 reset state: bus off while deselected, word 0 while selected
    #(CLK_P * 2);
    check_bus(0, 8'h00, "R1 reset bus off");
    ce_n = 0; oe_n = 0; #1;
    check_bus(1, 8'h00, "R1 reset addr");
    ce_n = 1; oe_n = 1;
    @(negedge clk);
    rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].ce, VEC[i].oe, VEC[i].we, VEC[i].avd, VEC[i].mode, VEC[i].len, VEC[i].addr);
      cyc_check(VEC[i].eoe, VEC[i].ea, $sformatf("R%0d row %0d", VEC[i].req, i));
    end

    // R10 reset in mid burst
    drive(1, 1, 1, 1, 1, 0, 8'h00);
    cyc_check(0, 8'h00, "R10 deselect");
    drive(0, 0, 1, 0, 1, 0, 8'h30);
    cyc_check(1, 8'h30, "R10 load");
    drive(0, 0, 1, 1, 1, 0, 8'h00);
    cyc_check(1, 8'h31, "R10 step");
    @(negedge clk);
    rst_n = 0;
    #1;
    check_bus(1, 8'h00, "R10 reset clears addr");
    @(negedge clk);
    rst_n = 1;
    cyc_check(1, 8'h00, "R10 async after reset");
    // R1 clocks do not advance after reset
    cyc_check(1, 8'h00, "R1 no advance");
    cyc_check(1, 8'h00, "R1 no advance 2");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule